// File: doc/BRIEF.md
# Interrupt and Status Flag Router

This block sits beside a CAN controller core and turns its event pulses and level conditions into a small set of hardware output pins. Event pulses are latched into sticky interrupt flags that the host clears by writing ones. Each flag is gated by its own bit in an interrupt enable register, and any gated flag raises the interrupt pin. Level conditions, such as FIFO fill and error state, show through a status flag register with no latching. A second enable register gates them onto the status pin.

Two general-purpose pins each mirror one chosen flag. A 5-bit select code picks the flag from either the interrupt set or the status set. A host reads and writes the block's registers through a single-cycle write strobe and a combinational read port. All pins are registered.

Top module: `flag_router`

## Requirements
- R1: After the asynchronous reset, the interrupt flags and both enable registers read zero. Both select registers read 5'h0F. The interrupt, status and general-purpose pins are low.
- R2: A one on bit b of evt_i sets interrupt flag b at the next clock edge. The flag stays set until the host clears it. The interrupt flags read at address 0.
- R3: A write to address 0 clears each interrupt flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R5: irq_o equals, one clock later, the OR over all bits of the interrupt flags ANDed with the interrupt enable register. That register sits at address 1.
- R6: Address 2 reads cond_i live, with no latching, and writes to address 2 have no effect.
- R7: stat_o equals, one clock later, the OR over all bits of cond_i ANDed with the status enable register. That register sits at address 3.
- R8: General-purpose pin g is set by the select register at address 4+g. Select bit 4 picks the source: 0 means the interrupt flags and 1 means the status flags. Bits 3:0 give the bit index. One clock later the pin carries that flag, or 0 when the index is 8 or above.
- R9: Writes to the enable and select registers read back the written data. For select registers only the low 5 bits are kept, and the upper bits read zero. Addresses 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses from the controller core |
| cond_i | input | 8 | Level status conditions from the controller core |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt pin |
| stat_o | output | 1 | Status pin |
| gp_o | output | 2 | General-purpose flag mirror pins |

## Verification
The hardest case to reach is an event landing on a flag in the very cycle the host clears that flag. Surrounding traffic must not hide the result. The bench stages this case directly, with a full clear and a single event in one cycle, and then reads the flag back. A long random phase then runs sparse events and frequent writes, so that clears and events overlap on many bit positions. That phase also sweeps the select codes, including the out-of-range indices, while a cycle-level model is compared on every clock.

// File: rtl/flag_router_pkg.sv
package flag_router_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 5;
  localparam int IDX_W  = SEL_W - 1;
  localparam logic [SEL_W-1:0] GSEL_RST = 5'h0F;

  typedef enum logic [ADDR_W-1:0] {
    ADR_IFLAG = 3'd0,
    ADR_IEN   = 3'd1,
    ADR_SFLAG = 3'd2,
    ADR_SEN   = 3'd3,
    ADR_GSEL0 = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] flag_o
);
  logic [NUM_IRQ-1:0] flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | evt_i;
  end

  assign flag_o = flag_q;

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_q) & ~$past(clr_i) & ~flag_q) == '0));
  // R4
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // R3
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(clr_i) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/flag_reg_file.sv
module flag_reg_file
  import flag_router_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_STAT = 8,
  parameter int NUM_GP   = 2,
  parameter int DW       = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DW-1:0]                  wdata_i,
  input  logic [NUM_IRQ-1:0]             iflag_i,
  input  logic [NUM_STAT-1:0]            cond_i,
  output logic [DW-1:0]                  rdata_o,
  output logic [NUM_IRQ-1:0]             clr_o,
  output logic [NUM_IRQ-1:0]             ien_o,
  output logic [NUM_STAT-1:0]            sen_o,
  output logic [NUM_GP-1:0][SEL_W-1:0]   gsel_o
);
  logic [NUM_IRQ-1:0]           ien_q;
  logic [NUM_STAT-1:0]          sen_q;
  logic [NUM_GP-1:0][SEL_W-1:0] gsel_q;

  assign clr_o = (wr_en_i && addr_i == ADR_IFLAG) ? wdata_i[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sen_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_IEN) ien_q <= wdata_i[NUM_IRQ-1:0];
      if (addr_i == ADR_SEN) sen_q <= wdata_i[NUM_STAT-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ADR_GSEL0) + ADDR_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         gsel_q[g] <= GSEL_RST;
      else if (wr_en_i && addr_i == MY_ADR) gsel_q[g] <= wdata_i[SEL_W-1:0];
    end
    // R9
    gsel_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == MY_ADR) |=> (gsel_q[g] == $past(wdata_i[SEL_W-1:0])));
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_IFLAG: rdata_o = DW'(iflag_i);
      ADR_IEN:   rdata_o = DW'(ien_q);
      ADR_SFLAG: rdata_o = DW'(cond_i);
      ADR_SEN:   rdata_o = DW'(sen_q);
      default: begin
        for (int g = 0; g < NUM_GP; g++)
          if (addr_i == ADDR_W'(ADR_GSEL0) + ADDR_W'(g)) rdata_o = DW'(gsel_q[g]);
      end
    endcase
  end

  assign ien_o  = ien_q;
  assign sen_o  = sen_q;
  assign gsel_o = gsel_q;

  // R9
  ien_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_IEN) |=> (ien_q == $past(wdata_i[NUM_IRQ-1:0])));
endmodule

// File: rtl/gp_flag_mux.sv
module gp_flag_mux
  import flag_router_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_STAT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_IRQ-1:0]  iflag_i,
  input  logic [NUM_STAT-1:0] sflag_i,
  output logic                gp_o
);
  logic [IDX_W-1:0] idx;
  logic             pick;
  logic             gp_q;

  assign idx = sel_i[IDX_W-1:0];

  // out-of-range index leaves pick low
  always_comb begin
    pick = 1'b0;
    if (sel_i[SEL_W-1]) begin
      for (int i = 0; i < NUM_STAT; i++)
        if (idx == IDX_W'(i)) pick = sflag_i[i];
    end else begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (idx == IDX_W'(i)) pick = iflag_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gp_q <= 1'b0;
    else         gp_q <= pick;
  end

  assign gp_o = gp_q;

  // R8
  gp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i[SEL_W-1] && 32'(idx) >= NUM_IRQ) |=> !gp_q);
  // R8
  gp_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[SEL_W-1] && 32'(idx) >= NUM_STAT) |=> !gp_q);
endmodule

// File: rtl/flag_router.sv
module flag_router
  import flag_router_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_STAT = 8,
  parameter int NUM_GP   = 2,
  parameter int DW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQ-1:0]  evt_i,
  input  logic [NUM_STAT-1:0] cond_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_o,
  output logic                stat_o,
  output logic [NUM_GP-1:0]   gp_o
);
  logic [NUM_IRQ-1:0]           iflag, clr, ien;
  logic [NUM_STAT-1:0]          sen;
  logic [NUM_GP-1:0][SEL_W-1:0] gsel;
  logic                         irq_q, stat_q;

  irq_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_flags (
    .clk_i (clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr), .flag_o(iflag)
  );

  flag_reg_file #(.NUM_IRQ(NUM_IRQ), .NUM_STAT(NUM_STAT), .NUM_GP(NUM_GP), .DW(DW)) u_regs (
    .clk_i  (clk_i),   .rst_ni (rst_ni),  .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .iflag_i(iflag),   .cond_i (cond_i),  .rdata_o(rdata_o),
    .clr_o  (clr),     .ien_o  (ien),     .sen_o  (sen),     .gsel_o(gsel)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    gp_flag_mux #(.NUM_IRQ(NUM_IRQ), .NUM_STAT(NUM_STAT)) u_mux (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(gsel[g]),
      .iflag_i(iflag), .sflag_i(cond_i), .gp_o(gp_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      irq_q  <= |(iflag & ien);
      stat_q <= |(cond_i & sen);
    end
  end

  assign irq_o  = irq_q;
  assign stat_o = stat_q;

  // R5
  irq_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(iflag & ien) != '0)));
  // R7
  stat_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_o == ($past(cond_i & sen) != '0)));
endmodule

// File: tb/flag_router_tb.sv
`timescale 1ns/1ps
module flag_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0, cond = '0, wdata = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] rdata;
  logic       irq, stat;
  logic [1:0] gp;

  int n_chk = 0, n_err = 0, wd = 0;

  always #2 clk = ~clk;

  flag_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cond_i(cond), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .stat_o(stat), .gp_o(gp)
  );

  // reference model
  logic [7:0] m_if, m_ie, m_se;
  logic [4:0] m_gs [2];
  logic       m_irq, m_stat;
  logic [1:0] m_gp;

  function automatic logic pick(logic [4:0] s, logic [7:0] fi, logic [7:0] fs);
    if (s[3:0] >= 4'd8) return 1'b0;
    return s[4] ? fs[s[2:0]] : fi[s[2:0]];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_if <= '0; m_ie <= '0; m_se <= '0; m_gs[0] <= 5'h0F; m_gs[1] <= 5'h0F;
      m_irq <= 0; m_stat <= 0; m_gp <= '0;
    end else begin
      m_irq  <= (m_if & m_ie) != 0;
      m_stat <= (cond & m_se) != 0;
      m_gp[0] <= pick(m_gs[0], m_if, cond);
      m_gp[1] <= pick(m_gs[1], m_if, cond);
      m_if <= (m_if & ~((wr_en && addr == 3'd0) ? wdata : 8'h00)) | evt;
      if (wr_en && addr == 3'd1) m_ie <= wdata;
      if (wr_en && addr == 3'd3) m_se <= wdata;
      if (wr_en && addr == 3'd4) m_gs[0] <= wdata[4:0];
      if (wr_en && addr == 3'd5) m_gs[1] <= wdata[4:0];
    end
  end

  function automatic logic [7:0] m_rd(logic [2:0] a);
    case (a)
      3'd0: return m_if;
      3'd1: return m_ie;
      3'd2: return cond;
      3'd3: return m_se;
      3'd4: return {3'b0, m_gs[0]};
      3'd5: return {3'b0, m_gs[1]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd2: return "R6";
      3'd4, 3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk({7'b0, irq}, {7'b0, m_irq}, "R5");
    chk({7'b0, stat}, {7'b0, m_stat}, "R7");
    chk({6'b0, gp}, {6'b0, m_gp}, "R8");
    chk(rdata, m_rd(addr), rd_tag(addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cyc();
    wr_en = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    addr = 3'd0; #0;
    chk({5'b0, irq, stat, 1'b0} | {6'b0, gp}, 8'h00, "R1");
    chk(rdata, 8'h00, "R1");
    rst_n = 1;
    addr = 3'd4; cyc(); chk(rdata, 8'h0F, "R1");
    addr = 3'd1; cyc(); chk(rdata, 8'h00, "R1");

    // R2 sticky set
    evt = 8'h24; addr = 3'd0; cyc(); evt = 0;
    repeat (3) cyc();
    chk(rdata, 8'h24, "R2");
    // R3 partial clear
    wr(3'd0, 8'h04); addr = 3'd0; cyc(); chk(rdata, 8'h20, "R3");
    // R5 enable path
    wr(3'd1, 8'h20); repeat (2) cyc(); chk({7'b0, irq}, 8'h01, "R5");
    // R4 event and clear same cycle
    wr_en = 1; addr = 3'd0; wdata = 8'hFF; evt = 8'h01; cyc();
    wr_en = 0; evt = 0; chk(rdata, 8'h01, "R4");
    cyc();
    // R6 live status, write ignored
    cond = 8'h5A; wr(3'd2, 8'hFF); addr = 3'd2; cyc(); chk(rdata, 8'h5A, "R6");
    // R7
    wr(3'd3, 8'h02); repeat (2) cyc(); chk({7'b0, stat}, 8'h01, "R7");
    // R8 select codes: status bit 3, irq bit 0, out of range
    wr(3'd4, 8'h13); wr(3'd5, 8'h00); repeat (2) cyc();
    chk({6'b0, gp}, 8'h03, "R8");
    wr(3'd4, 8'h1C); wr(3'd5, 8'h08); repeat (2) cyc();
    chk({6'b0, gp}, 8'h00, "R8");
    // R9 upper bits dropped, unmapped addresses
    wr(3'd5, 8'hE7); addr = 3'd5; cyc(); chk(rdata, 8'h07, "R9");
    wr(3'd6, 8'hAA); addr = 3'd6; cyc(); chk(rdata, 8'h00, "R9");
    wr(3'd7, 8'h55); addr = 3'd7; cyc(); chk(rdata, 8'h00, "R9");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      evt   = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      if (($urandom % 8) == 0) cond = 8'($urandom);
      wr_en = (($urandom % 3) == 0);
      addr  = 3'($urandom);
      wdata = 8'($urandom);
      cyc();
    end
    wr_en = 0; evt = 0;
    cyc();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule